// File: doc/BRIEF.md
# Register-to-Register Vector Execution Unit

This block executes integer vector instructions entirely between registers. It contains a file of eight vector registers, each holding 64 elements of 64 bits, plus a vector-length register that software sets through a separate write port. A single issued instruction names an operation, two source registers and a destination register. The unit then walks the elements from index 0 upward, one element per clock. It stops after the count held in the length register when the instruction was accepted. Elements beyond that count in the destination are left untouched.

Instructions enter through a valid/ready handshake. Ready is high only while the unit is idle. The controller is a three-state machine. `S_IDLE` waits for an issue. `S_RUN` writes one destination element per cycle. `S_DONE` lasts one cycle and signals completion. The transitions are as follows. `S_IDLE -> S_RUN` happens on an accepted issue with a valid opcode and a non-zero length. `S_IDLE -> S_DONE` happens on an accepted issue with length zero or an unknown opcode. `S_RUN -> S_DONE` happens when the last element is written. `S_DONE -> S_IDLE` always follows. An element-level debug port reads any element at any time. The same port can write an element while the unit is idle, which is how register contents are loaded and inspected around the execution unit.

Top module: `vexu_top`

## Requirements
- R1: The file holds 8 registers (3-bit select) of 64 elements (6-bit index) of 64 bits. All elements read zero after reset. `dbg_rdata` combinationally returns element `dbg_idx` of register `dbg_sel`. When `dbg_we` is high and the unit is idle, `dbg_wdata` is written to that element at the clock edge.
- R2: Opcode values select the operation on each element pair (A, B). 3'b000 gives A+B modulo 2^64. 3'b001 gives A-B modulo 2^64. 3'b010 gives A AND B. 3'b011 gives A OR B. 3'b100 gives A XOR B.
- R3: An instruction with captured length L writes destination elements 0 to L-1 only. Destination elements L to 63 and all other registers keep their contents.
- R4: A write to the length register stores 64 when the written 7-bit value exceeds 64, and stores the value otherwise. After reset the length is 64.
- R5: With length 0, an accepted instruction writes nothing. `busy` and `done` are high together for exactly one cycle, and then the unit is idle.
- R6: An issue is accepted on a clock edge where `iss_valid` and `iss_ready` are both high. `iss_ready` is high exactly when `busy` is low. For a valid opcode and length L>0, `busy` stays high for L+1 cycles after acceptance. `done` is high only in the last of those cycles, for one cycle.
- R7: Opcodes 3'b101, 3'b110 and 3'b111 are accepted but write nothing. They finish like a length-0 instruction, with one busy cycle and a done pulse.
- R8: The length is captured at acceptance. A length-register write while busy does not change the instruction in flight, but it applies to the next instruction.
- R9: A debug write requested while `busy` is high is ignored.
- R10: The destination may equal either source. Each element is computed from the source values at the same index before that element is overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction offered |
| iss_ready | output | 1 | Unit idle and able to accept |
| iss_op | input | 3 | Operation code |
| iss_src_a | input | 3 | First source register |
| iss_src_b | input | 3 | Second source register |
| iss_dst | input | 3 | Destination register |
| len_we | input | 1 | Length register write strobe |
| len_wdata | input | 7 | Requested length, clamped to 64 |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| dbg_we | input | 1 | Debug element write (idle only) |
| dbg_sel | input | 3 | Debug register select |
| dbg_idx | input | 6 | Debug element index |
| dbg_wdata | input | 64 | Debug write data |
| dbg_rdata | output | 64 | Debug read data |

## Verification
On every cycle the assertions check that an accepted issue raises `busy` and that `done` is a single pulse followed by idle. They also check that the stored length never exceeds 64, that every element write lands below the captured length, that the element index advances by one per write, and that the captured length holds still while the unit runs. Only the bench scenarios can show the arithmetic results of each opcode, and that elements at and above the length keep their contents. The same applies to in-place operation, the effect of a mid-flight length write on the following instruction, and the discarding of debug writes made while busy. Those are shown by comparing every destination element against a bench-side model after each instruction.

// File: rtl/vexu_pkg.sv
package vexu_pkg;
    localparam int NREG  = 8;
    localparam int NELEM = 64;
    localparam int EW    = 64;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100
    } vop_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } vstate_e;

    function automatic logic op_known(input logic [2:0] op);
        return op <= OP_XOR;
    endfunction
endpackage

// File: rtl/vexu_len_reg.sv
module vexu_len_reg #(
    parameter int NELEM = vexu_pkg::NELEM,
    localparam int LW = $clog2(NELEM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [LW-1:0] wdata,
    output logic [LW-1:0] len_q
);
    localparam logic [LW-1:0] LMAX = LW'(NELEM);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= LMAX;
        end else if (we) begin
            len_q <= (wdata > LMAX) ? LMAX : wdata;
        end
    end
endmodule

// File: rtl/vexu_alu.sv
module vexu_alu #(
    parameter int EW = vexu_pkg::EW
) (
    input  logic [2:0]    op,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    output logic [EW-1:0] y
);
    import vexu_pkg::*;

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/vexu_vrf.sv
module vexu_vrf #(
    parameter int NREG  = vexu_pkg::NREG,
    parameter int NELEM = vexu_pkg::NELEM,
    parameter int EW    = vexu_pkg::EW,
    localparam int RW = $clog2(NREG),
    localparam int IW = $clog2(NELEM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] a_sel,
    input  logic [RW-1:0] b_sel,
    input  logic [IW-1:0] rd_idx,
    output logic [EW-1:0] a_data,
    output logic [EW-1:0] b_data,
    input  logic [RW-1:0] p_sel,
    input  logic [IW-1:0] p_idx,
    output logic [EW-1:0] p_data,
    input  logic          we,
    input  logic [RW-1:0] w_sel,
    input  logic [IW-1:0] w_idx,
    input  logic [EW-1:0] w_data
);
    logic [EW-1:0] mem [NREG][NELEM];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                for (int e = 0; e < NELEM; e++) begin
                    mem[r][e] <= '0;
                end
            end
        end else if (we) begin
            mem[w_sel][w_idx] <= w_data;
        end
    end

    assign a_data = mem[a_sel][rd_idx];
    assign b_data = mem[b_sel][rd_idx];
    assign p_data = mem[p_sel][p_idx];
endmodule

// File: rtl/vexu_ctrl.sv
module vexu_ctrl #(
    parameter int NREG  = vexu_pkg::NREG,
    parameter int NELEM = vexu_pkg::NELEM,
    localparam int RW = $clog2(NREG),
    localparam int IW = $clog2(NELEM),
    localparam int LW = $clog2(NELEM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [2:0]    iss_op,
    input  logic [RW-1:0] iss_src_a,
    input  logic [RW-1:0] iss_src_b,
    input  logic [RW-1:0] iss_dst,
    input  logic [LW-1:0] len_cur,
    output logic          iss_ready,
    output logic          busy,
    output logic          done,
    output logic          wr_en,
    output logic [IW-1:0] idx,
    output logic [LW-1:0] len_cap,
    output logic [2:0]    op_q,
    output logic [RW-1:0] a_q,
    output logic [RW-1:0] b_q,
    output logic [RW-1:0] d_q
);
    import vexu_pkg::*;

    vstate_e state, state_nx;
    logic    accept;
    logic    last_elem;

    assign accept    = iss_valid && (state == S_IDLE);
    assign last_elem = ({1'b0, idx} == (len_cap - LW'(1)));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (accept) begin
                state_nx = (len_cur == '0 || !op_known(iss_op)) ? S_DONE : S_RUN;
            end
            S_RUN:  if (last_elem) state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            idx     <= '0;
            len_cap <= '0;
            op_q    <= '0;
            a_q     <= '0;
            b_q     <= '0;
            d_q     <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                idx     <= '0;
                len_cap <= len_cur;
                op_q    <= iss_op;
                a_q     <= iss_src_a;
                b_q     <= iss_src_b;
                d_q     <= iss_dst;
            end else if (state == S_RUN && !last_elem) begin
                idx <= idx + IW'(1);
            end
        end
    end

    always_comb begin
        iss_ready = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        wr_en     = 1'b0;
        unique case (state)
            S_IDLE: iss_ready = 1'b1;
            S_RUN: begin
                busy  = 1'b1;
                wr_en = 1'b1;
            end
            S_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: iss_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/vexu_top.sv
module vexu_top (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        iss_valid,
    output logic        iss_ready,
    input  logic [2:0]  iss_op,
    input  logic [2:0]  iss_src_a,
    input  logic [2:0]  iss_src_b,
    input  logic [2:0]  iss_dst,
    input  logic        len_we,
    input  logic [6:0]  len_wdata,
    output logic        busy,
    output logic        done,
    input  logic        dbg_we,
    input  logic [2:0]  dbg_sel,
    input  logic [5:0]  dbg_idx,
    input  logic [63:0] dbg_wdata,
    output logic [63:0] dbg_rdata
);
    import vexu_pkg::*;
    localparam int RW = $clog2(NREG);
    localparam int IW = $clog2(NELEM);
    localparam int LW = $clog2(NELEM + 1);

    logic [LW-1:0] len_q;
    logic [LW-1:0] len_cap;
    logic          wr_en;
    logic [IW-1:0] exec_idx;
    logic [2:0]    op_q;
    logic [RW-1:0] a_q, b_q, d_q;
    logic [EW-1:0] a_data, b_data, alu_y;
    logic          dbg_ok;
    logic          vrf_we;
    logic [RW-1:0] vrf_wsel;
    logic [IW-1:0] vrf_widx;
    logic [EW-1:0] vrf_wdata;

    vexu_len_reg #(.NELEM(NELEM)) i_len (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (len_we),
        .wdata (len_wdata),
        .len_q (len_q)
    );

    vexu_ctrl #(.NREG(NREG), .NELEM(NELEM)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .iss_op    (iss_op),
        .iss_src_a (iss_src_a),
        .iss_src_b (iss_src_b),
        .iss_dst   (iss_dst),
        .len_cur   (len_q),
        .iss_ready (iss_ready),
        .busy      (busy),
        .done      (done),
        .wr_en     (wr_en),
        .idx       (exec_idx),
        .len_cap   (len_cap),
        .op_q      (op_q),
        .a_q       (a_q),
        .b_q       (b_q),
        .d_q       (d_q)
    );

    vexu_alu #(.EW(EW)) i_alu (
        .op (op_q),
        .a  (a_data),
        .b  (b_data),
        .y  (alu_y)
    );

    assign dbg_ok    = dbg_we && !busy;
    assign vrf_we    = wr_en || dbg_ok;
    assign vrf_wsel  = wr_en ? d_q      : dbg_sel;
    assign vrf_widx  = wr_en ? exec_idx : dbg_idx;
    assign vrf_wdata = wr_en ? alu_y    : dbg_wdata;

    vexu_vrf #(.NREG(NREG), .NELEM(NELEM), .EW(EW)) i_vrf (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_sel  (a_q),
        .b_sel  (b_q),
        .rd_idx (exec_idx),
        .a_data (a_data),
        .b_data (b_data),
        .p_sel  (dbg_sel),
        .p_idx  (dbg_idx),
        .p_data (dbg_rdata),
        .we     (vrf_we),
        .w_sel  (vrf_wsel),
        .w_idx  (vrf_widx),
        .w_data (vrf_wdata)
    );
endmodule

// File: rtl/vexu_chk.sv
module vexu_chk #(
    parameter int NELEM = vexu_pkg::NELEM,
    localparam int IW = $clog2(NELEM),
    localparam int LW = $clog2(NELEM + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic          busy,
    input logic          done,
    input logic          wr_en,
    input logic [IW-1:0] idx,
    input logic [LW-1:0] len_q,
    input logic [LW-1:0] len_cap
);
    // R6: accepted issue makes the unit busy on the next cycle
    p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> busy);

    // R6 / R5: done lasts one cycle and is followed by idle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R4: stored length never exceeds the element count
    p_len_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LW'(NELEM));

    // R3: element writes stay below the captured length
    p_write_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, idx} < len_cap));

    // R6: consecutive element writes step the index by one
    p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (idx == $past(idx) + IW'(1)));

    // R8: captured length is frozen while running
    p_len_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(len_cap));
endmodule

bind vexu_top vexu_chk #(.NELEM(vexu_pkg::NELEM)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .busy      (busy),
    .done      (done),
    .wr_en     (wr_en),
    .idx       (exec_idx),
    .len_q     (len_q),
    .len_cap   (len_cap)
);

// File: tb/test_vexu_top.sv
module test_vexu_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        iss_valid;
    logic        iss_ready;
    logic [2:0]  iss_op, iss_src_a, iss_src_b, iss_dst;
    logic        len_we;
    logic [6:0]  len_wdata;
    logic        busy, done;
    logic        dbg_we;
    logic [2:0]  dbg_sel;
    logic [5:0]  dbg_idx;
    logic [63:0] dbg_wdata, dbg_rdata;

    always #2 clk = ~clk;

    vexu_top i_vexu_top (.*);

    logic [63:0] model [8][64];
    int len_model;
    int total = 0;
    int bad = 0;

    function automatic logic [63:0] ref_op(input int op, input logic [63:0] a, input logic [63:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            default: return a ^ b;
        endcase
    endfunction

    function automatic int clamp_len(input int v);
        return (v > 64) ? 64 : v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic dbg_put(input int r, input int e, input logic [63:0] v);
        @(negedge clk);
        dbg_we = 1'b1; dbg_sel = r[2:0]; dbg_idx = e[5:0]; dbg_wdata = v;
        @(negedge clk);
        dbg_we = 1'b0;
        model[r][e] = v;
    endtask

    task automatic check_reg(input string req, input int r);
        for (int e = 0; e < 64; e++) begin
            @(negedge clk);
            dbg_sel = r[2:0]; dbg_idx = e[5:0];
            #1;
            chk(req, dbg_rdata, model[r][e], $sformatf("reg%0d[%0d]", r, e));
        end
    endtask

    task automatic set_len(input int v);
        @(negedge clk);
        len_we = 1'b1; len_wdata = v[6:0];
        @(negedge clk);
        len_we = 1'b0;
        len_model = clamp_len(v);
    endtask

    // mid_len >= 0: length write at the second busy cycle; poke: debug write while busy
    task automatic run_op(input int op, input int a, input int b, input int d,
                          input int mid_len, input bit poke, input string req);
        int eff, nb, nd, expb;
        eff = len_model;
        @(negedge clk);
        chk("R6", {63'd0, iss_ready}, 64'd1, "ready before issue");
        iss_valid = 1'b1; iss_op = op[2:0];
        iss_src_a = a[2:0]; iss_src_b = b[2:0]; iss_dst = d[2:0];
        @(negedge clk);
        iss_valid = 1'b0;
        nb = 0; nd = 0;
        while (busy && nb < 300) begin
            nb++;
            if (done) nd++;
            if (iss_ready) chk("R6", 64'd1, 64'd0, "ready while busy");
            if (nb == 2 && mid_len >= 0) begin
                len_we = 1'b1; len_wdata = mid_len[6:0];
            end else begin
                len_we = 1'b0;
            end
            if (nb == 2 && poke) begin
                dbg_we = 1'b1; dbg_sel = d[2:0]; dbg_idx = 6'd63; dbg_wdata = 64'hDEAD_BEEF_0BAD_F00D;
            end else begin
                dbg_we = 1'b0;
            end
            @(negedge clk);
        end
        len_we = 1'b0; dbg_we = 1'b0;
        if (mid_len >= 0) len_model = clamp_len(mid_len);
        expb = (op <= 4 && eff > 0) ? eff + 1 : 1;
        chk(req, 64'(nb), 64'(expb), "busy cycles");
        chk(req, 64'(nd), 64'd1, "done pulses");
        if (op <= 4) begin
            for (int e = 0; e < eff; e++) begin
                model[d][e] = ref_op(op, model[a][e], model[b][e]);
            end
        end
        check_reg(req, d);
    endtask

    initial begin
        iss_valid = 0; iss_op = 0; iss_src_a = 0; iss_src_b = 0; iss_dst = 0;
        len_we = 0; len_wdata = 0; dbg_we = 0; dbg_sel = 0; dbg_idx = 0; dbg_wdata = 0;
        void'($urandom(32'd1234));
        for (int r = 0; r < 8; r++)
            for (int e = 0; e < 64; e++) model[r][e] = '0;
        len_model = 64;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R6 reset state
        chk("R6", {63'd0, busy}, 64'd0, "busy after reset");
        chk("R6", {63'd0, done}, 64'd0, "done after reset");
        chk("R6", {63'd0, iss_ready}, 64'd1, "ready after reset");
        check_reg("R1", 7);

        // R1: load every element through the debug port
        for (int r = 0; r < 8; r++)
            for (int e = 0; e < 64; e++) dbg_put(r, e, {$urandom, $urandom});
        check_reg("R1", 0);
        check_reg("R1", 5);

        // R2: each operation over full length (R4 reset length 64)
        run_op(0, 0, 1, 2, -1, 0, "R2");
        run_op(1, 3, 4, 5, -1, 0, "R2");
        run_op(2, 1, 6, 7, -1, 0, "R2");
        run_op(3, 6, 0, 3, -1, 0, "R2");
        run_op(4, 2, 5, 4, -1, 0, "R2");
        // R2 wrap-around corners
        dbg_put(0, 0, 64'hFFFF_FFFF_FFFF_FFFF); dbg_put(1, 0, 64'd1);
        set_len(1);
        run_op(0, 0, 1, 6, -1, 0, "R2");
        run_op(1, 1, 0, 6, -1, 0, "R2");

        // R4: over-range length clamps to 64
        set_len(100);
        run_op(4, 3, 2, 1, -1, 0, "R4");
        set_len(127);
        run_op(0, 5, 5, 0, -1, 0, "R4");

        // R3: partial length leaves upper elements alone
        set_len(5);
        run_op(1, 2, 3, 4, -1, 0, "R3");
        check_reg("R3", 2);
        set_len(63);
        run_op(3, 7, 1, 0, -1, 0, "R3");

        // R5: length zero
        set_len(0);
        run_op(0, 1, 2, 3, -1, 0, "R5");

        // R7: unknown opcodes
        set_len(10);
        run_op(5, 1, 2, 3, -1, 0, "R7");
        run_op(7, 4, 4, 4, -1, 0, "R7");

        // R8: length write in flight; new value used next time
        set_len(12);
        run_op(0, 2, 3, 5, 3, 0, "R8");
        run_op(4, 5, 1, 6, -1, 0, "R8");

        // R9: debug write while busy is dropped
        set_len(20);
        run_op(2, 0, 7, 1, -1, 1, "R9");

        // R10: in place operation
        set_len(64);
        run_op(0, 3, 3, 3, -1, 0, "R10");
        run_op(1, 4, 2, 2, -1, 0, "R10");

        // random mix
        for (int k = 0; k < 30; k++) begin
            set_len($urandom_range(0, 90));
            run_op($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                   $urandom_range(0, 7), -1, 0, "R3");
        end
        for (int r = 0; r < 8; r++) check_reg("R3", r);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R6 watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule